// File: doc/BRIEF.md
# Linked-List Memory-to-Memory DMA Channel

This block is one memory-to-memory DMA channel that copies a chain of blocks. Software programs a source address, a destination address, a control word and a pointer to the next descriptor, then sets the enable bit. The channel moves the block one word at a time over a single-word memory master port. At the end of the block it either finishes or reads the next four-word descriptor from memory, reloads its registers and starts the next block.

A source-reload option restores the source address to the value software first wrote before each new block. The descriptor's source word is then skipped. A per-block interrupt can make the channel pause between blocks until software acknowledges it. While the reload option is on, the chain keeps running. Once software turns it off, the block that ends next is the last one.

Top module: `llp_dma_channel`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req`, `irq`, `blk_stat` and `done_stat` are all 0, and no memory request is made while `busy` is 0.
- R2: Registers are selected by `reg_addr`: 0 source, 1 destination, 2 next-descriptor pointer, 3 control, 4 configuration (bit 0 enable, bit 1 source reload), 5 mask (bit 0 masks the block interrupt), 6 status clear. Writing configuration with bit 0 set while idle starts a transfer, and `busy` stays 1 until the transfer ends.
- R3: The control word gives the block length in words in bits 11:0. Each word is a read at the source address followed by a write of the read data at the destination address. Both addresses then advance by 4. A length of 0 produces no memory access.
- R4: Between blocks the channel reads four words at pointer+0, +4, +8 and +12, in that order. These load source (reload off), destination, next pointer and control, and the next block uses them.
- R5: With the reload bit set, every block after a descriptor fetch starts at the source address software wrote, and descriptor word 0 has no effect.
- R6: When a block ends with control bit 12 set and the mask bit 0, `blk_stat` goes to 1. If the transfer goes on, the channel makes no memory request until software writes status clear with bit 0 set.
- R7: If control bit 12 is 0 or the block interrupt is masked, `blk_stat` is not set and the next descriptor fetch starts without waiting.
- R8: A block ends the transfer when control bit 13 (chaining enable) is 0 or the pointer register is 0. `done_stat` is then set, `busy` falls and no further descriptor is read.
- R9: After the reload bit has been set for a block of the current transfer, a block that ends while the bit is clear is the last block, even if chaining is enabled and the pointer is non-zero.
- R10: While `busy` is 1, writes to registers 0, 1, 2, 3 and 5 and to the enable bit are ignored. Only the reload bit and the status clear register take writes.
- R11: If a block-end sets `blk_stat` in the same cycle that software clears it, `blk_stat` stays 1 and the channel stays paused.
- R12: `irq` is 1 whenever `blk_stat` or `done_stat` is 1. Writing status clear with bit 1 set clears `done_stat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted this cycle |
| busy | output | 1 | Transfer in progress |
| blk_stat | output | 1 | Block-complete status |
| done_stat | output | 1 | Transfer-complete status |
| irq | output | 1 | Interrupt request |

## Verification
The delicate coincidence is the block-end that sets the block status landing in the same cycle as a software write that clears it. If the clear won, the paused channel would miss its own event and restart without an acknowledge. The bench provokes this by acknowledging every request at once. It watches for the final write of a block to be accepted and issues the clear write in the very next cycle, which is the block-end cycle. It then expects `blk_stat` still at 1 and no memory request for several cycles, and only a second clear lets the descriptor fetch go ahead.

// File: rtl/llp_dma_pkg.sv
package llp_dma_pkg;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int LEN_W  = 12;
  localparam int IE_BIT = LEN_W;      // block interrupt enable
  localparam int LL_BIT = LEN_W + 1;  // chaining enable
  localparam int CTL_W  = LL_BIT + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RD, ST_WR, ST_END, ST_STALL, ST_FETCH
  } dma_state_e;

  typedef enum logic [2:0] {
    RA_SRC  = 3'd0,
    RA_DST  = 3'd1,
    RA_LLP  = 3'd2,
    RA_CTRL = 3'd3,
    RA_CFG  = 3'd4,
    RA_MASK = 3'd5,
    RA_CLR  = 3'd6
  } reg_sel_e;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(4);
  endfunction

  function automatic logic [AW-1:0] desc_addr(input logic [AW-1:0] base,
                                              input logic [1:0] idx);
    return base + {{(AW-4){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic is_last_block(input logic ll_en, input logic llp_zero,
                                         input logic rl_seen, input logic reload);
    return !ll_en || llp_zero || (rl_seen && !reload);
  endfunction
endpackage

// File: rtl/llp_dma_path.sv
module llp_dma_path
  import llp_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  dma_state_e        state,
  input  logic [1:0]        fidx,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              rd_ack,
  input  logic              word_done,
  input  logic              fetch_ack,
  input  logic              reload,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [LEN_W-1:0]  len,
  output logic              int_en,
  output logic              ll_en,
  output logic              llp_zero
);
  logic [AW-1:0]    src_init, src, dst, llp, llp_nxt;
  logic [CTL_W-1:0] ctrl;
  logic [DW-1:0]    data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_init <= '0; src <= '0; dst <= '0; llp <= '0;
      llp_nxt  <= '0; ctrl <= '0; data <= '0;
    end else begin
      if (sw_we) begin
        case (reg_sel_e'(reg_addr))
          RA_SRC:  begin src_init <= reg_wdata; src <= reg_wdata; end
          RA_DST:  dst  <= reg_wdata;
          RA_LLP:  llp  <= reg_wdata;
          RA_CTRL: ctrl <= reg_wdata[CTL_W-1:0];
          default: ;
        endcase
      end
      if (rd_ack) data <= mem_rdata;
      if (word_done) begin
        src <= step_addr(src);
        dst <= step_addr(dst);
      end
      if (fetch_ack) begin
        case (fidx)
          2'd0: src     <= reload ? src_init : mem_rdata;
          2'd1: dst     <= mem_rdata;
          2'd2: llp_nxt <= mem_rdata;
          default: begin
            ctrl <= mem_rdata[CTL_W-1:0];
            llp  <= llp_nxt;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_WR:    mem_addr = dst;
      ST_FETCH: mem_addr = desc_addr(llp, fidx);
      default:  mem_addr = src;
    endcase
  end

  assign mem_wdata = data;
  assign len       = ctrl[LEN_W-1:0];
  assign int_en    = ctrl[IE_BIT];
  assign ll_en     = ctrl[LL_BIT];
  assign llp_zero  = (llp == '0);
endmodule

// File: rtl/llp_dma_ctl.sv
module llp_dma_ctl
  import llp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mem_ack,
  input  logic [LEN_W-1:0] len,
  input  logic             int_en,
  input  logic             ll_en,
  input  logic             llp_zero,
  input  logic             reload,
  input  logic             mask,
  input  logic             clr_blk,
  output dma_state_e       state,
  output logic [1:0]       fidx,
  output logic             mem_req,
  output logic             mem_we,
  output logic             rd_ack,
  output logic             word_done,
  output logic             fetch_ack,
  output logic             blk_end,
  output logic             blk_set,
  output logic             xfer_end,
  output logic             stalled
);
  logic [LEN_W-1:0] cnt;
  logic             rl_seen;
  logic             last;
  dma_state_e       nxt;

  assign mem_req   = (state == ST_RD) || (state == ST_WR) || (state == ST_FETCH);
  assign mem_we    = (state == ST_WR);
  assign rd_ack    = (state == ST_RD) && mem_ack;
  assign word_done = (state == ST_WR) && mem_ack;
  assign fetch_ack = (state == ST_FETCH) && mem_ack;
  assign blk_end   = (state == ST_END);
  assign stalled   = (state == ST_STALL);
  assign last      = is_last_block(ll_en, llp_zero, rl_seen, reload);
  assign blk_set   = blk_end && int_en && !mask;
  assign xfer_end  = blk_end && last;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (en) nxt = ST_START;
      ST_START: nxt = (len == '0) ? ST_END : ST_RD;
      ST_RD:    if (mem_ack) nxt = ST_WR;
      ST_WR:    if (mem_ack) nxt = (cnt == LEN_W'(1)) ? ST_END : ST_RD;
      ST_END:   nxt = last ? ST_IDLE : (blk_set ? ST_STALL : ST_FETCH);
      ST_STALL: if (clr_blk) nxt = ST_FETCH;
      ST_FETCH: if (mem_ack && fidx == 2'd3) nxt = ST_START;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rl_seen <= 1'b0;
      fidx    <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE) rl_seen <= 1'b0;
      if (state == ST_START) begin
        cnt     <= len;
        rl_seen <= rl_seen | reload;
      end
      if (word_done) cnt <= cnt - LEN_W'(1);
      if (fetch_ack) fidx <= fidx + 2'd1;
    end
  end
endmodule

// File: rtl/llp_dma_stat.sv
module llp_dma_stat
  import llp_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [1:0] wbits,
  input  logic       busy,
  input  logic       blk_set,
  input  logic       xfer_end,
  output logic       en,
  output logic       reload,
  output logic       mask,
  output logic       clr_blk,
  output logic       blk_stat,
  output logic       done_stat,
  output logic       irq
);
  logic cfg_wr, mask_wr, clr_wr, clr_done;

  assign cfg_wr   = reg_we && (reg_sel_e'(reg_addr) == RA_CFG);
  assign mask_wr  = reg_we && (reg_sel_e'(reg_addr) == RA_MASK);
  assign clr_wr   = reg_we && (reg_sel_e'(reg_addr) == RA_CLR);
  assign clr_blk  = clr_wr && wbits[0];
  assign clr_done = clr_wr && wbits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; reload <= 1'b0; mask <= 1'b0;
      blk_stat <= 1'b0; done_stat <= 1'b0;
    end else begin
      if (xfer_end)              en <= 1'b0;
      else if (cfg_wr && !busy)  en <= wbits[0];
      if (cfg_wr)                reload <= wbits[1];
      if (mask_wr && !busy)      mask <= wbits[0];
      if (blk_set)               blk_stat <= 1'b1;
      else if (clr_blk)          blk_stat <= 1'b0;
      if (xfer_end)              done_stat <= 1'b1;
      else if (clr_done)         done_stat <= 1'b0;
    end
  end

  assign irq = blk_stat | done_stat;
endmodule

// File: rtl/llp_dma_channel.sv
module llp_dma_channel
  import llp_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          blk_stat,
  output logic          done_stat,
  output logic          irq
);
  dma_state_e       state;
  logic [1:0]       fidx;
  logic [LEN_W-1:0] len;
  logic             int_en, ll_en, llp_zero;
  logic             en, reload, mask, clr_blk;
  logic             rd_ack, word_done, fetch_ack;
  logic             blk_end, blk_set, xfer_end, stalled;
  logic             sw_we;

  assign busy  = en || (state != ST_IDLE);
  assign sw_we = reg_we && !busy;

  llp_dma_stat u_stat (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wbits(reg_wdata[1:0]), .busy(busy), .blk_set(blk_set), .xfer_end(xfer_end),
    .en(en), .reload(reload), .mask(mask), .clr_blk(clr_blk),
    .blk_stat(blk_stat), .done_stat(done_stat), .irq(irq)
  );

  llp_dma_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .mem_ack(mem_ack), .len(len),
    .int_en(int_en), .ll_en(ll_en), .llp_zero(llp_zero), .reload(reload),
    .mask(mask), .clr_blk(clr_blk), .state(state), .fidx(fidx),
    .mem_req(mem_req), .mem_we(mem_we), .rd_ack(rd_ack), .word_done(word_done),
    .fetch_ack(fetch_ack), .blk_end(blk_end), .blk_set(blk_set),
    .xfer_end(xfer_end), .stalled(stalled)
  );

  llp_dma_path u_path (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .state(state), .fidx(fidx), .mem_rdata(mem_rdata),
    .rd_ack(rd_ack), .word_done(word_done), .fetch_ack(fetch_ack),
    .reload(reload), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .len(len),
    .int_en(int_en), .ll_en(ll_en), .llp_zero(llp_zero)
  );
endmodule

// File: rtl/llp_dma_chk.sv
module llp_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mem_req,
  input logic stalled,
  input logic blk_end,
  input logic blk_set,
  input logic xfer_end,
  input logic clr_blk,
  input logic blk_stat,
  input logic done_stat
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r6_pause_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !mem_req);

  a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    blk_set |=> blk_stat);

  a_r6_clear_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && clr_blk) |=> !stalled);

  a_r7_no_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !blk_set) |=> !stalled);

  a_r8_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (!busy && done_stat));

  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_set && clr_blk) |=> (blk_stat && stalled || blk_stat && !busy));
endmodule

bind llp_dma_channel llp_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .stalled(stalled),
  .blk_end(blk_end), .blk_set(blk_set), .xfer_end(xfer_end), .clr_blk(clr_blk),
  .blk_stat(blk_stat), .done_stat(done_stat)
);

// File: tb/test_llp_dma_channel.sv
module test_llp_dma_channel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, blk_stat, done_stat, irq;

  llp_dma_channel i_llp_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .busy(busy), .blk_stat(blk_stat),
    .done_stat(done_stat), .irq(irq)
  );

  localparam logic [31:0] IE = 32'h1000;
  localparam logic [31:0] LL = 32'h2000;

  logic [31:0] mem [0:1023];
  logic        ack_all;
  logic [7:0]  lfsr;
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } acc_t;
  acc_t exp_q[$];

  assign mem_ack   = mem_req && (ack_all || lfsr[0] || lfsr[3]);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h5A;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n && mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: each accepted access is compared with the queue head
  always @(negedge clk) begin
    acc_t e;
    if (rst_n && mem_req && mem_ack) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 R4 R8 access not expected", mem_addr, 32'h0);
      else begin
        e = exp_q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
            "R3 R4 access order/address/data", e.we ? mem_wdata : mem_addr,
            e.we ? e.data : e.addr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL R2 watchdog: cycles=%0d expected below 60000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic exp_copy(input logic [31:0] s, input logic [31:0] d, input int n);
    acc_t a;
    for (int i = 0; i < n; i++) begin
      a.we = 1'b0; a.addr = s + 32'(4 * i); a.data = '0;
      exp_q.push_back(a);
      a.we = 1'b1; a.addr = d + 32'(4 * i); a.data = rd(s + 32'(4 * i));
      exp_q.push_back(a);
    end
  endtask

  task automatic exp_fetch(input logic [31:0] p);
    acc_t a;
    for (int i = 0; i < 4; i++) begin
      a.we = 1'b0; a.addr = p + 32'(4 * i); a.data = '0;
      exp_q.push_back(a);
    end
  endtask

  task automatic put_desc(input logic [31:0] p, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] nx,
                          input logic [31:0] c);
    mem[p[11:2]]        = s;
    mem[p[11:2] + 10'd1] = d;
    mem[p[11:2] + 10'd2] = nx;
    mem[p[11:2] + 10'd3] = c;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] p, input logic [31:0] c);
    wreg(3'd0, s); wreg(3'd1, d); wreg(3'd2, p); wreg(3'd3, c);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; ack_all = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 | 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !mem_req, "R1 idle after reset", {30'd0, busy, mem_req}, 32'h0);
    chk(!irq && !blk_stat && !done_stat, "R1 status after reset",
        {29'd0, irq, blk_stat, done_stat}, 32'h0);

    // single block, busy-time writes ignored
    setup(32'h100, 32'h700, 32'h0, 32'd6);
    exp_copy(32'h100, 32'h700, 6);
    wreg(3'd4, 32'h1);
    chk(busy, "R2 enable starts transfer", {31'd0, busy}, 32'h1);
    wreg(3'd0, 32'h0000_0300); wreg(3'd1, 32'h0000_0B00);
    wreg(3'd2, 32'h0000_0300); wreg(3'd4, 32'h0);   // R10 ignored while busy
    wait_idle();
    chk(exp_q.size() == 0, "R10 R3 all copy accesses seen", 32'(exp_q.size()), 32'h0);
    chk(done_stat && !busy, "R8 done after single block", {30'd0, done_stat, busy}, 32'h2);
    chk(!blk_stat, "R7 no block status with bit12 clear", {31'd0, blk_stat}, 32'h0);
    chk(irq, "R12 irq follows done status", {31'd0, irq}, 32'h1);
    chk(mem[32'h714 >> 2] == rd(32'h114), "R3 last word copied", mem[32'h714 >> 2], rd(32'h114));
    wreg(3'd6, 32'h2);
    chk(!irq && !done_stat, "R12 done cleared by bit1", {30'd0, irq, done_stat}, 32'h0);

    // zero length block
    setup(32'h100, 32'h780, 32'h0, 32'h0);
    wreg(3'd4, 32'h1);
    wait_idle();
    chk(done_stat && exp_q.size() == 0, "R3 zero length moves nothing",
        {31'd0, done_stat}, 32'h1);
    chk(mem[32'h780 >> 2] == (32'hA500_0000 | 32'(32'h780 >> 2)), "R3 zero length dest untouched",
        mem[32'h780 >> 2], 32'hA500_0000 | 32'(32'h780 >> 2));
    wreg(3'd6, 32'h3);

    // chain without reload, ended by null pointer
    put_desc(32'h240, 32'h140, 32'h820, 32'h250, 32'd1 | LL);
    put_desc(32'h250, 32'h150, 32'h840, 32'h0, 32'd2 | LL | IE);
    setup(32'h120, 32'h800, 32'h240, 32'd2 | LL);
    exp_copy(32'h120, 32'h800, 2);
    exp_fetch(32'h240); exp_copy(32'h140, 32'h820, 1);
    exp_fetch(32'h250); exp_copy(32'h150, 32'h840, 2);
    wreg(3'd4, 32'h1);
    wait_idle();
    chk(exp_q.size() == 0, "R4 chain accesses complete", 32'(exp_q.size()), 32'h0);
    chk(mem[32'h844 >> 2] == rd(32'h154), "R4 source from descriptor word0",
        mem[32'h844 >> 2], rd(32'h154));
    chk(done_stat && blk_stat, "R8 R6 null pointer ends with status",
        {30'd0, done_stat, blk_stat}, 32'h3);
    wreg(3'd6, 32'h3);

    // reload with pause, then reload switched off
    wreg(3'd5, 32'h0);
    put_desc(32'h200, 32'h180, 32'h500, 32'h210, 32'd2 | IE | LL);
    put_desc(32'h210, 32'h180, 32'h600, 32'h220, 32'd1 | IE | LL);
    put_desc(32'h220, 32'h1C0, 32'h680, 32'h230, 32'd1 | LL);
    setup(32'h100, 32'h400, 32'h200, 32'd2 | IE | LL);
    exp_copy(32'h100, 32'h400, 2);
    wreg(3'd4, 32'h3);
    while (!blk_stat) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(!mem_req && busy && irq, "R6 paused after block", {29'd0, mem_req, busy, irq}, 32'h3);
    exp_fetch(32'h200); exp_copy(32'h100, 32'h500, 2);
    wreg(3'd6, 32'h1);
    while (!blk_stat) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && mem[32'h504 >> 2] == rd(32'h104), "R5 source restored",
        mem[32'h504 >> 2], rd(32'h104));
    wreg(3'd4, 32'h0);
    exp_fetch(32'h210); exp_copy(32'h180, 32'h600, 1);
    wreg(3'd6, 32'h1);
    wait_idle();
    chk(done_stat && exp_q.size() == 0, "R9 block after reload off is last",
        {31'd0, done_stat}, 32'h1);
    wreg(3'd6, 32'h3);

    // masked interrupt with reload: no pause, no status
    wreg(3'd5, 32'h1);
    put_desc(32'h260, 32'h1F0, 32'h910, 32'h270, 32'd2 | IE);
    setup(32'h160, 32'h900, 32'h260, 32'd1 | IE | LL);
    exp_copy(32'h160, 32'h900, 1);
    exp_fetch(32'h260); exp_copy(32'h160, 32'h910, 2);
    wreg(3'd4, 32'h3);
    wait_idle();
    chk(!blk_stat && done_stat, "R7 masked block no status", {30'd0, blk_stat, done_stat}, 32'h1);
    chk(exp_q.size() == 0, "R5 R7 masked chain complete", 32'(exp_q.size()), 32'h0);
    wreg(3'd6, 32'h3);
    wreg(3'd5, 32'h0);
    wreg(3'd4, 32'h0);

    // clear write in the block-end cycle
    ack_all = 1'b1;
    put_desc(32'h280, 32'h104, 32'hA10, 32'h0, 32'd1);
    setup(32'h100, 32'hA00, 32'h280, 32'd1 | IE | LL);
    exp_copy(32'h100, 32'hA00, 1);
    wreg(3'd4, 32'h1);
    do @(negedge clk); while (!(mem_req && mem_we && mem_ack));
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h1;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(blk_stat && !mem_req && busy, "R11 set wins over clear",
        {29'd0, blk_stat, mem_req, busy}, 32'h5);
    exp_fetch(32'h280); exp_copy(32'h104, 32'hA10, 1);
    wreg(3'd6, 32'h1);
    wait_idle();
    chk(done_stat && exp_q.size() == 0, "R11 second clear resumes", {31'd0, done_stat}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule